// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file for a processor that keeps procedure context in registers. Its physical storage is a ring of windows plus a small group of global registers. Each instruction names a register with a 5-bit number that is relative to the current window pointer. A call moves the pointer one window forward, and a return moves it one window back. The outgoing group of a caller and the incoming group of its callee are the same physical registers, so arguments reach the callee without any copy.

When a call would take over a window that still belongs to an older frame, the block raises an overflow trap. When a return would land on a window that is no longer resident, it raises an underflow trap. Trap software then uses the spill stream to move the oldest resident window out to memory, or the fill stream to bring the caller's window back. After that, the software reissues the call or return. A saved window pointer marks the oldest resident window.

The controller has three states. `ST_IDLE` accepts calls and returns. `ST_SPILL` streams one window out. `ST_FILL` writes one window back. The transitions are named as follows:
- SPILL_GO: `ST_IDLE` to `ST_SPILL` on `spill_start`.
- FILL_GO: `ST_IDLE` to `ST_FILL` on `fill_start`, when `spill_start` is low.
- SPILL_DONE: `ST_SPILL` to `ST_IDLE` on the 16th accepted beat.
- FILL_DONE: `ST_FILL` to `ST_IDLE` on the 16th accepted beat.

Top module: `regwin_file`

## Requirements
- R1: After reset, every logical register reads zero, `cwp` and `swp` are 0, both traps are low and `spill_valid` is low.
- R2: Logical registers 0–7 are global and map to the same storage from every window. Register 0 always reads zero, and writes to it are dropped.
- R3: Logical registers 8–15 are incoming, 16–23 local and 24–31 outgoing. Outgoing register 24+k of window w is the same storage as incoming register 8+k of window (w+1) mod 8. Local registers belong to their own window only.
- R4: In `ST_IDLE`, a call that does not overflow makes `cwp` one higher (mod 8) from the next cycle. A return that does not underflow makes it one lower.
- R5: In `ST_IDLE`, a call while (cwp+2) mod 8 equals `swp` leaves `cwp` unchanged and pulses `ovf_trap` for one cycle, starting in the next cycle.
- R6: In `ST_IDLE`, a return while `cwp` equals `swp` leaves `cwp` unchanged and pulses `unf_trap` for one cycle, starting in the next cycle.
- R7: A call and a return in the same cycle have no effect. Calls and returns are also ignored in `ST_SPILL` and `ST_FILL`.
- R8: `spill_start` in `ST_IDLE` streams window `swp`: beat k (0..15) carries incoming registers 8..15 for k<8, then local registers 16..23. `spill_valid` is high throughout, and a beat advances on `spill_valid && spill_ready`. Data holds steady while stalled. The last beat increments `swp` (mod 8).
- R9: `fill_start` (with `spill_start` low) in `ST_IDLE` writes 16 `fill_valid` beats, in the same order as R8, into window (swp−1) mod 8. The last beat decrements `swp` (mod 8).
- R10: A read of the register being written in the same cycle returns the new write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| ra_addr | input | 5 | Read port A logical register |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 5 | Read port B logical register |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write logical register |
| wr_data | input | 32 | Write data |
| ovf_trap | output | 1 | Window overflow trap pulse |
| unf_trap | output | 1 | Window underflow trap pulse |
| cwp | output | 3 | Current window pointer |
| swp | output | 3 | Saved window pointer (oldest resident window) |
| spill_start | input | 1 | Begin spilling window `swp` |
| spill_valid | output | 1 | Spill beat available |
| spill_ready | input | 1 | Spill beat accepted |
| spill_data | output | 32 | Spill beat data |
| fill_start | input | 1 | Begin filling window swp−1 |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill beat data |

## Verification
The hardest states to reach are a full ring and a ring emptied below its oldest frame. Reaching them takes a nest of six calls without a spill, or returns past the saved pointer. A random walk biased toward calls and returns drives the pointers around the whole ring several times. Every predicted trap is answered with a spill or fill under random ready/valid stalls, and then the call or return is retried. Windows that are spilled and later reused by deeper frames make sure that a fill really restores the data.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } rwf_state_e;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_IN     = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_OUT    = 2'd3
    } rwf_group_e;
endpackage

// File: rtl/rwf_addr_map.sv
module rwf_addr_map
    import rwf_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int NWIN = 8,
    localparam int GW    = $clog2(GRP),
    localparam int LAW   = GW + 2,
    localparam int WPW   = $clog2(NWIN),
    localparam int SLOT  = 2 * GRP,
    localparam int NPHYS = GRP + NWIN * SLOT,
    localparam int PAW   = $clog2(NPHYS)
) (
    input  logic [WPW-1:0] win,
    input  logic [LAW-1:0] laddr,
    output logic [PAW-1:0] paddr
);
    rwf_group_e     grp;
    logic [GW-1:0]  idx;
    logic [WPW-1:0] win_next;

    always_comb begin
        grp      = rwf_group_e'(laddr[LAW-1 -: 2]);
        idx      = laddr[GW-1:0];
        win_next = win + WPW'(1);
        unique case (grp)
            GRP_GLOBAL: paddr = PAW'(idx);
            GRP_IN:     paddr = PAW'(GRP) + PAW'(win) * PAW'(SLOT) + PAW'(idx);
            GRP_LOCAL:  paddr = PAW'(GRP) + PAW'(win) * PAW'(SLOT) + PAW'(GRP) + PAW'(idx);
            GRP_OUT:    paddr = PAW'(GRP) + PAW'(win_next) * PAW'(SLOT) + PAW'(idx);
            default:    paddr = '0;
        endcase
    end
endmodule

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
    import rwf_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int NWIN = 8,
    localparam int WPW  = $clog2(NWIN),
    localparam int SLOT = 2 * GRP,
    localparam int BW   = $clog2(SLOT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           spill_start,
    input  logic           spill_ready,
    input  logic           fill_start,
    input  logic           fill_valid,
    output rwf_state_e     state,
    output logic [WPW-1:0] cwp,
    output logic [WPW-1:0] swp,
    output logic [BW-1:0]  beat,
    output logic           ovf_trap,
    output logic           unf_trap
);
    rwf_state_e state_nxt;
    logic idle, call_only, ret_only, ovf_cond, unf_cond, beat_fire, beat_last;

    always_comb begin
        idle      = (state == ST_IDLE);
        call_only = call_i & ~ret_i;
        ret_only  = ret_i & ~call_i;
        ovf_cond  = ((cwp + WPW'(2)) == swp);
        unf_cond  = (cwp == swp);
        beat_fire = ((state == ST_SPILL) & spill_ready) | ((state == ST_FILL) & fill_valid);
        beat_last = beat_fire & (beat == BW'(SLOT - 1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (spill_start)     state_nxt = ST_SPILL;
                else if (fill_start) state_nxt = ST_FILL;
            end
            ST_SPILL: if (beat_last) state_nxt = ST_IDLE;
            ST_FILL:  if (beat_last) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp      <= '0;
            swp      <= '0;
            beat     <= '0;
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
        end else begin
            ovf_trap <= idle & call_only & ovf_cond;
            unf_trap <= idle & ret_only & unf_cond;
            if (idle & call_only & ~ovf_cond)    cwp <= cwp + WPW'(1);
            else if (idle & ret_only & ~unf_cond) cwp <= cwp - WPW'(1);
            if (idle || beat_last)  beat <= '0;
            else if (beat_fire)     beat <= beat + BW'(1);
            if (beat_last) begin
                if (state == ST_SPILL) swp <= swp + WPW'(1);
                else                   swp <= swp - WPW'(1);
            end
        end
    end
endmodule

// File: rtl/rwf_regs.sv
module rwf_regs #(
    parameter int DW    = 32,
    parameter int NPHYS = 136,
    parameter int NRD   = 2,
    localparam int PAW  = $clog2(NPHYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [PAW-1:0]            wa,
    input  logic [DW-1:0]             wd,
    input  logic                      fe,
    input  logic [PAW-1:0]            fa,
    input  logic [DW-1:0]             fd,
    input  logic [NRD-1:0][PAW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]    rdata,
    input  logic [PAW-1:0]            sa,
    output logic [DW-1:0]             sd
);
    logic [DW-1:0] rf [NPHYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
        end else begin
            if (we && wa != '0) rf[wa] <= wd;
            if (fe)             rf[fa] <= fd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0)                rdata[p] = '0;
            else if (we && wa == raddr[p])     rdata[p] = wd;
            else                               rdata[p] = rf[raddr[p]];
        end
    end

    assign sd = rf[sa];
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import rwf_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int GW    = $clog2(GRP),
    localparam int LAW   = GW + 2,
    localparam int WPW   = $clog2(NWIN),
    localparam int SLOT  = 2 * GRP,
    localparam int BW    = $clog2(SLOT),
    localparam int NPHYS = GRP + NWIN * SLOT,
    localparam int PAW   = $clog2(NPHYS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic [LAW-1:0] ra_addr,
    output logic [DW-1:0]  ra_data,
    input  logic [LAW-1:0] rb_addr,
    output logic [DW-1:0]  rb_data,
    input  logic           wr_en,
    input  logic [LAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic           ovf_trap,
    output logic           unf_trap,
    output logic [WPW-1:0] cwp,
    output logic [WPW-1:0] swp,
    input  logic           spill_start,
    output logic           spill_valid,
    input  logic           spill_ready,
    output logic [DW-1:0]  spill_data,
    input  logic           fill_start,
    input  logic           fill_valid,
    input  logic [DW-1:0]  fill_data
);
    rwf_state_e              state;
    logic [BW-1:0]           beat;
    logic [2:0][LAW-1:0]     laddr;
    logic [2:0][PAW-1:0]     paddr;
    logic [1:0][PAW-1:0]     rd_pa;
    logic [1:0][DW-1:0]      rd_d;
    logic [WPW-1:0]          fill_win;
    logic [PAW-1:0]          spill_pa, fill_pa;
    logic                    fill_we;

    rwf_ctrl #(.GRP(GRP), .NWIN(NWIN)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .spill_start(spill_start), .spill_ready(spill_ready),
        .fill_start(fill_start), .fill_valid(fill_valid),
        .state(state), .cwp(cwp), .swp(swp), .beat(beat),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    assign laddr[0] = ra_addr;
    assign laddr[1] = rb_addr;
    assign laddr[2] = wr_addr;

    for (genvar g = 0; g < 3; g++) begin : g_map
        rwf_addr_map #(.GRP(GRP), .NWIN(NWIN)) map_i (
            .win(cwp), .laddr(laddr[g]), .paddr(paddr[g])
        );
    end

    assign rd_pa[0] = paddr[0];
    assign rd_pa[1] = paddr[1];
    assign fill_win = swp - WPW'(1);
    assign spill_pa = PAW'(GRP) + PAW'(swp) * PAW'(SLOT) + PAW'(beat);
    assign fill_pa  = PAW'(GRP) + PAW'(fill_win) * PAW'(SLOT) + PAW'(beat);
    assign fill_we  = (state == ST_FILL) & fill_valid;

    rwf_regs #(.DW(DW), .NPHYS(NPHYS), .NRD(2)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wa(paddr[2]), .wd(wr_data),
        .fe(fill_we), .fa(fill_pa), .fd(fill_data),
        .raddr(rd_pa), .rdata(rd_d),
        .sa(spill_pa), .sd(spill_data)
    );

    assign ra_data     = rd_d[0];
    assign rb_data     = rd_d[1];
    assign spill_valid = (state == ST_SPILL);
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
    parameter int WPW = 3,
    parameter int LAW = 5,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [WPW-1:0] cwp,
    input logic [WPW-1:0] swp,
    input logic           ovf_trap,
    input logic           unf_trap,
    input logic           spill_valid,
    input logic           spill_ready,
    input logic [DW-1:0]  spill_data,
    input logic [LAW-1:0] ra_addr,
    input logic [DW-1:0]  ra_data
);
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == '0) |-> (ra_data == '0)); // R2

    AST_CWP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cwp) |-> (cwp == $past(cwp) + WPW'(1) || cwp == $past(cwp) - WPW'(1))); // R4

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> $stable(cwp)); // R5

    AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> $stable(cwp)); // R6

    AST_ONE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap)); // R7

    AST_SPILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_valid && !spill_ready) |=> (spill_valid && $stable(spill_data))); // R8

    AST_SWP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swp) |-> (swp == $past(swp) + WPW'(1) || swp == $past(swp) - WPW'(1))); // R9
endmodule

bind regwin_file regwin_file_chk #(.WPW(WPW), .LAW(LAW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cwp(cwp), .swp(swp),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap),
    .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_data(spill_data),
    .ra_addr(ra_addr), .ra_data(ra_data)
);

// File: tb/regwin_file_tb_top.sv
module regwin_file_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GRP   = 8;
    localparam int NWIN  = 8;
    localparam int DW    = 32;
    localparam int SLOT  = 2 * GRP;
    localparam int NPHYS = GRP + NWIN * SLOT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic call_i = 0, ret_i = 0, wr_en = 0;
    logic [4:0] ra_addr = 0, rb_addr = 0, wr_addr = 0;
    logic [DW-1:0] wr_data = 0, fill_data = 0;
    logic spill_start = 0, spill_ready = 0, fill_start = 0, fill_valid = 0;
    logic [DW-1:0] ra_data, rb_data, spill_data;
    logic ovf_trap, unf_trap, spill_valid;
    logic [2:0] cwp, swp;

    regwin_file #(.GRP(GRP), .NWIN(NWIN), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap), .cwp(cwp), .swp(swp),
        .spill_start(spill_start), .spill_valid(spill_valid), .spill_ready(spill_ready),
        .spill_data(spill_data), .fill_start(fill_start), .fill_valid(fill_valid),
        .fill_data(fill_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    int mc = 0, ms = 0;
    logic [DW-1:0] m  [NPHYS];
    logic [DW-1:0] bk [NWIN][SLOT];

    function automatic int phys(int w, int l);
        int g = l / GRP, i = l % GRP;
        if (g == 0) return i;
        if (g == 1) return GRP + w * SLOT + i;
        if (g == 2) return GRP + w * SLOT + GRP + i;
        return GRP + ((w + 1) % NWIN) * SLOT + i;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_check(int a, int b, string req);
        ra_addr = 5'(a);
        rb_addr = 5'(b);
        #1;
        check(req, ra_data, m[phys(mc, a)]);
        check(req, rb_data, m[phys(mc, b)]);
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        wr_en = 1; wr_addr = 5'(a); wr_data = d;
        tick();
        wr_en = 0;
        if (phys(mc, a) != 0) m[phys(mc, a)] = d;
    endtask

    task automatic do_call(output bit trapped);
        call_i = 1;
        tick();
        call_i = 0;
        trapped = ((mc + 2) % NWIN == ms);
        if (trapped) begin
            check("R5 ovf_trap", 32'(ovf_trap), 32'd1);
            check("R5 cwp held", 32'(cwp), 32'(mc));
        end else begin
            mc = (mc + 1) % NWIN;
            check("R4 call cwp", 32'(cwp), 32'(mc));
            check("R5 no ovf", 32'(ovf_trap), 32'd0);
        end
    endtask

    task automatic do_ret(output bit trapped);
        ret_i = 1;
        tick();
        ret_i = 0;
        trapped = (mc == ms);
        if (trapped) begin
            check("R6 unf_trap", 32'(unf_trap), 32'd1);
            check("R6 cwp held", 32'(cwp), 32'(mc));
        end else begin
            mc = (mc + NWIN - 1) % NWIN;
            check("R4 ret cwp", 32'(cwp), 32'(mc));
            check("R6 no unf", 32'(unf_trap), 32'd0);
        end
    endtask

    task automatic do_spill();
        int k = 0;
        bit poked = 0;
        spill_start = 1;
        tick();
        spill_start = 0;
        while (k < SLOT) begin
            spill_ready = ($urandom % 3) != 0;
            if (!poked && k == 3) begin call_i = 1; poked = 1; end
            #1;
            check("R8 spill_valid", 32'(spill_valid), 32'd1);
            check("R8 spill_data", spill_data, m[GRP + ms * SLOT + k]);
            bk[ms][k] = m[GRP + ms * SLOT + k];
            tick();
            call_i = 0;
            if (spill_ready) k++;
        end
        spill_ready = 0;
        ms = (ms + 1) % NWIN;
        #1;
        check("R8 swp after spill", 32'(swp), 32'(ms));
        check("R8 spill_valid low", 32'(spill_valid), 32'd0);
        check("R7 call ignored in spill", 32'(cwp), 32'(mc));
    endtask

    task automatic do_fill();
        int k = 0;
        int slot = (ms + NWIN - 1) % NWIN;
        fill_start = 1;
        tick();
        fill_start = 0;
        while (k < SLOT) begin
            fill_valid = ($urandom % 3) != 0;
            fill_data  = bk[slot][k];
            tick();
            if (fill_valid) begin
                m[GRP + slot * SLOT + k] = bk[slot][k];
                k++;
            end
        end
        fill_valid = 0;
        ms = slot;
        check("R9 swp after fill", 32'(swp), 32'(ms));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit t;
        logic [DW-1:0] v;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < NPHYS; i++) m[i] = '0;
        for (int w = 0; w < NWIN; w++)
            for (int k = 0; k < SLOT; k++) bk[w][k] = $urandom;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 32; a += 2) rd_check(a, a + 1, "R1 reset read");
        check("R1 cwp", 32'(cwp), 0);
        check("R1 swp", 32'(swp), 0);
        check("R1 traps", 32'({ovf_trap, unf_trap}), 0);
        check("R1 spill_valid", 32'(spill_valid), 0);

        // R6 / R9: return from the top frame underflows; fill window 7, then retry
        do_ret(t);
        check("R6 first ret traps", 32'(t), 1);
        do_fill();
        do_ret(t);
        for (int a = 8; a < 24; a += 2) rd_check(a, a + 1, "R9 filled window");

        // R2 globals and zero register
        wr(3, 32'hCAFE0003);
        wr(0, 32'hDEADBEEF);
        do_call(t);
        rd_check(3, 0, "R2 global across windows");

        // R3 outgoing becomes incoming
        for (int k = 0; k < GRP; k++) wr(24 + k, 32'hA0000000 + 32'(k));
        wr(16, 32'h10C41000);
        do_call(t);
        for (int k = 0; k < GRP; k++) begin
            ra_addr = 5'(8 + k);
            #1;
            check("R3 overlap", ra_data, 32'hA0000000 + 32'(k));
        end
        rd_check(16, 17, "R3 local private");

        // R7 call and return together
        call_i = 1; ret_i = 1;
        tick();
        call_i = 0; ret_i = 0;
        check("R7 both strobes cwp", 32'(cwp), 32'(mc));
        check("R7 both strobes traps", 32'({ovf_trap, unf_trap}), 0);

        // R10 write-through
        wr_en = 1; wr_addr = 5'd20; wr_data = 32'h0B1A5501; ra_addr = 5'd20;
        #1;
        check("R10 bypass", ra_data, 32'h0B1A5501);
        tick();
        wr_en = 0;
        m[phys(mc, 20)] = 32'h0B1A5501;

        // R5 / R8: call until the ring fills, spill, retry
        for (int n = 0; n < NWIN; n++) begin
            do_call(t);
            if (t) begin
                do_spill();
                do_call(t);
                check("R5 retry after spill", 32'(t), 0);
                break;
            end
        end

        // constrained random walk
        for (int it = 0; it < 3000; it++) begin
            int r = $urandom % 100;
            if (r < 30) begin
                wr($urandom % 32, $urandom);
            end else if (r < 50) begin
                rd_check($urandom % 32, $urandom % 32, "R3 random read");
            end else if (r < 72) begin
                do_call(t);
                if (t) begin do_spill(); do_call(t); end
            end else if (r < 94) begin
                do_ret(t);
                if (t) begin do_fill(); do_ret(t); end
            end else if (r < 97) begin
                int a = $urandom % 32;
                v = $urandom;
                wr_en = 1; wr_addr = 5'(a); wr_data = v; ra_addr = 5'(a);
                #1;
                check("R10 random bypass", ra_data, (a == 0) ? '0 : v);
                tick();
                wr_en = 0;
                if (a != 0) m[phys(mc, a)] = v;
            end else begin
                call_i = 1; ret_i = 1;
                tick();
                call_i = 0; ret_i = 0;
                check("R7 random both", 32'(cwp), 32'(mc));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule